// File: doc/BRIEF.md
# Bus Clock Band Classifier

This block works out which of four frequency bands the bus clock falls into, so that a timing selector elsewhere can pick its settings. Each pass starts with a one-cycle start request. A 32-bit stored frequency word is presented with the request. When the upper bits of that word carry a fixed validity signature, its low 9 bits are taken as the frequency count and no measurement is made. When the signature is missing, the block instead takes 128 samples of an external 9-bit count, one every programmable number of cycles, and uses their floor average.

The resulting count is weighted by a per-device base constant. It is then graded against three band edges that are pre-multiplied by the divisor, so no divider is built. The result is a 2-bit band index, which stays on its output until the next result, and a one-cycle valid pulse. A sample strobe output tells the count producer in which cycles its value is taken.

Top module: `bus_clk_band`

## Requirements
- R1: While reset is asserted and until the first result, `sample_o` and `valid_o` are low and `band_o` is 0.
- R2: If `stored_word_i[31:12]` equals 0xABCDE when `start_i` is sampled, the count is `stored_word_i[8:0]`. No sample strobe follows, and `valid_o` is high in the cycle after the second rising edge that comes after the edge that sampled `start_i`.
- R3: Any other word starts a measurement of exactly 128 samples. With gap value g, `sample_o` is first high in the cycle after g edges past the start edge, and then every g+1 cycles. `count_i` is taken at the edge that ends each strobe cycle. `valid_o` follows 2 edges after the last sample is taken, so the total latency is 128·(g+1)+2 edges.
- R4: The measured count is the floor of the 128-sample sum divided by 128. The sum never wraps.
- R5: The scaled frequency is floor(base × count / 192), where base is `base_i`.
- R6: The band is 0 below 40, 1 from 40 to below 45, 2 from 45 to below 55, and 3 from 55 upward (values in MHz).
- R7: `valid_o` is a pulse that lasts exactly one cycle for each completed pass.
- R8: A `start_i` in any state restarts the pass. Samples already taken are discarded, and a result still in flight is never reported.
- R9: `band_o` changes only together with a `valid_o` pulse. The value on `count_i` in cycles where `sample_o` is low has no effect.
- R10: `base_i`, `gap_i` and `stored_word_i` are read only at the edge that samples `start_i`. Later changes do not affect that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin a pass |
| stored_word_i | input | 32 | Stored frequency word with the signature in bits 31:12 |
| base_i | input | 7 | Per-device base constant |
| gap_i | input | 8 | Idle cycles between samples |
| count_i | input | 9 | Frequency count sample |
| sample_o | output | 1 | High in cycles whose `count_i` is taken |
| band_o | output | 2 | Band index of the latest result |
| valid_o | output | 1 | One-cycle result pulse |

## Verification
A wrong sample pacer or a wrong sample index shows at the ports within one sample interval: either a `sample_o` strobe lands off its expected cycle, or `valid_o` arrives early or late, up to about 130·(g+1) cycles after the start. An accumulator that is not cleared, or that takes values outside strobe cycles, shows only in `band_o` when the result pulse arrives. The stimuli are therefore chosen so that such an error moves the result across a band edge, for example averages of 159.5 against 160. A stuck sequencer shows as a missing or doubled `valid_o`, which the cycle-by-cycle comparison flags in the first cycle where it differs.

// File: rtl/bcb_pkg.sv
package bcb_pkg;
  localparam int unsigned BAND_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_SCALE  = 2'd2,
    ST_CLASS  = 2'd3
  } bcb_state_e;
endpackage

// File: rtl/bcb_pacer.sv
// Paces the sample strobe and counts samples of one measurement.
module bcb_pacer #(
  parameter int unsigned GAP_W = 8,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             strobe_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = '1;

  logic [GAP_W-1:0] gap_q, gap_d;
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign strobe_o = run_i && (cnt_q == gap_q);
  assign last_o   = strobe_o && (idx_q == IDX_LAST);

  always_comb begin
    gap_d = gap_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (restart_i) begin
      gap_d = gap_i;
      cnt_d = '0;
      idx_d = '0;
    end else if (strobe_o) begin
      cnt_d = '0;
      idx_d = idx_q + 1'b1;
    end else if (run_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      gap_q <= gap_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  // R3: the interval counter never passes the captured gap
  p_gap_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= gap_q));
endmodule

// File: rtl/bcb_accum.sv
// Sums the samples; exposes the floor average including the sample in flight.
module bcb_accum #(
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned LOG2_N = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             add_i,
  input  logic [CNT_W-1:0] sample_i,
  output logic [CNT_W-1:0] avg_o
);
  localparam int unsigned ACC_W = CNT_W + LOG2_N;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] sum_w;

  assign sum_w = acc_q + ACC_W'(sample_i);
  assign avg_o = sum_w[ACC_W-1:LOG2_N];

  always_comb begin
    acc_d = acc_q;
    if (clear_i) acc_d = '0;
    else if (add_i) acc_d = sum_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else acc_q <= acc_d;
  end

  // R4: an addition never wraps the sum
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !clear_i) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/bcb_grader.sv
// Weights the count by the base constant and grades against pre-scaled edges.
module bcb_grader
  import bcb_pkg::*;
#(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned BASE_W  = 7,
  parameter int unsigned DIVISOR = 192,
  parameter int unsigned EDGE1   = 40,
  parameter int unsigned EDGE2   = 45,
  parameter int unsigned EDGE3   = 55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              judge_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [BAND_W-1:0] band_o,
  output logic              valid_o
);
  localparam int unsigned PROD_W = CNT_W + BASE_W;
  localparam int unsigned N_EDGE = (1 << BAND_W) - 1;

  logic [PROD_W-1:0] prod_q, prod_d;
  logic [BAND_W-1:0] band_q, band_d, band_w;
  logic              valid_q, valid_d;
  logic [N_EDGE-1:0] over_w;

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    localparam int unsigned EDGE_MHZ = (g == 0) ? EDGE1 : ((g == 1) ? EDGE2 : EDGE3);
    localparam logic [PROD_W-1:0] LIM = PROD_W'(EDGE_MHZ * DIVISOR);
    assign over_w[g] = (prod_q >= LIM);
  end

  assign band_w = BAND_W'($countones(over_w));

  always_comb begin
    prod_d  = prod_q;
    band_d  = band_q;
    valid_d = judge_i;
    if (load_i) prod_d = PROD_W'(base_i) * PROD_W'(count_i);
    if (judge_i) band_d = band_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      band_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prod_q  <= prod_d;
      band_q  <= band_d;
      valid_q <= valid_d;
    end
  end

  assign band_o  = band_q;
  assign valid_o = valid_q;

  // R7: the result pulse lasts one cycle
  p_valid_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R9: the band moves only with a result pulse
  p_band_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(band_o) |-> valid_o);
endmodule

// File: rtl/bus_clk_band.sv
module bus_clk_band
  import bcb_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned SIG_LSB = 12,
  parameter logic [WORD_W-SIG_LSB-1:0] SIG = 20'hABCDE,
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned LOG2_N  = 7,
  parameter int unsigned BASE_W  = 7,
  parameter int unsigned GAP_W   = 8,
  parameter int unsigned DIVISOR = 192,
  parameter int unsigned EDGE1   = 40,
  parameter int unsigned EDGE2   = 45,
  parameter int unsigned EDGE3   = 55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] stored_word_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              sample_o,
  output logic [1:0]        band_o,
  output logic              valid_o
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  bcb_state_e        state_q, state_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              sig_ok, strobe, last, load, judge;
  logic [CNT_W-1:0]  avg;
  logic              unused_word_bits;

  assign sig_ok           = (stored_word_i[WORD_W-1:SIG_LSB] == SIG);
  assign unused_word_bits = ^stored_word_i[SIG_LSB-1:CNT_W];

  always_comb begin
    state_d = state_q;
    count_d = count_q;
    base_d  = base_q;
    if (start_i) begin
      base_d = base_i;
      if (sig_ok) begin
        state_d = ST_SCALE;
        count_d = stored_word_i[CNT_W-1:0];
      end else begin
        state_d = ST_SAMPLE;
      end
    end else begin
      case (state_q)
        ST_SAMPLE: if (last) begin
          state_d = ST_SCALE;
          count_d = avg;
        end
        ST_SCALE: state_d = ST_CLASS;
        ST_CLASS: state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      count_q <= count_d;
      base_q  <= base_d;
    end
  end

  assign load  = (state_q == ST_SCALE);
  assign judge = (state_q == ST_CLASS) && !start_i;

  bcb_pacer #(.GAP_W(GAP_W), .IDX_W(LOG2_N)) u_pacer (
    .clk_i     (clk_i),
    .rst_ni    (rst_sn),
    .restart_i (start_i),
    .run_i     (state_q == ST_SAMPLE),
    .gap_i     (gap_i),
    .strobe_o  (strobe),
    .last_o    (last)
  );

  bcb_accum #(.CNT_W(CNT_W), .LOG2_N(LOG2_N)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_sn),
    .clear_i  (start_i),
    .add_i    (strobe && !start_i),
    .sample_i (count_i),
    .avg_o    (avg)
  );

  bcb_grader #(
    .CNT_W(CNT_W), .BASE_W(BASE_W), .DIVISOR(DIVISOR),
    .EDGE1(EDGE1), .EDGE2(EDGE2), .EDGE3(EDGE3)
  ) u_grader (
    .clk_i   (clk_i),
    .rst_ni  (rst_sn),
    .load_i  (load),
    .judge_i (judge),
    .count_i (count_q),
    .base_i  (base_q),
    .band_o  (band_o),
    .valid_o (valid_o)
  );

  assign sample_o = strobe;

  // R8: a new request suppresses any result in flight
  p_restart_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_sn)
    start_i |=> !valid_o);
  // R2: a signed word yields a result two edges later
  p_fast_path_r2: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (start_i && sig_ok) ##1 !start_i ##1 !start_i |=> valid_o);
  // R2: a signed word never raises the sample strobe
  p_fast_nostrobe_r2: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (start_i && sig_ok) |=> !sample_o);
endmodule

// File: tb/bus_clk_band_test.sv
module bus_clk_band_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [31:0] word = '0;
  logic [6:0] base = 7'd48;
  logic [7:0] gap = '0;
  logic [8:0] count = '0;
  logic       sample;
  logic [1:0] band;
  logic       valid;

  always #4 clk = ~clk; // 8 time units per cycle: 125 MHz

  bus_clk_band uut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .stored_word_i (word),
    .base_i (base), .gap_i (gap), .count_i (count),
    .sample_o (sample), .band_o (band), .valid_o (valid)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    pat_mode = 0;   // 0 constant, 1 ramp by sample index
  int    pat_val = 0;

  // behavioural reference state
  int   m_mode = 0;      // 0 idle, 1 sampling, 2 waiting for result
  int   m_tick = 0, m_n = 0, m_sum = 0, m_cnt = 0, m_wait = 0;
  int   m_base = 0, m_gap = 0;
  logic exp_sample = 1'b0, exp_valid = 1'b0;
  logic [1:0] exp_band = 2'd0;

  function automatic int ref_band(int b, int c);
    int f;
    f = (b * c) / 192;
    if (f < 40) return 0;
    if (f < 45) return 1;
    if (f < 55) return 2;
    return 3;
  endfunction

  function automatic logic [31:0] signed_word(int c);
    return {20'hABCDE, 3'b000, 9'(c)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_mode = 0; exp_sample = 1'b0; exp_valid = 1'b0; exp_band = 2'd0;
    end else begin
      exp_valid = 1'b0;
      if (start) begin
        m_base = int'(base);
        m_gap  = int'(gap);
        if (word[31:12] == 20'hABCDE) begin
          m_mode = 2; m_wait = 1; m_cnt = int'(word[8:0]);
        end else begin
          m_mode = 1; m_tick = 0; m_n = 0; m_sum = 0;
        end
      end else if (m_mode == 1) begin
        if (m_tick == m_gap) begin
          m_sum += int'(count);
          m_n++;
          m_tick = 0;
          if (m_n == 128) begin
            m_cnt = m_sum / 128; m_mode = 2; m_wait = 1;
          end
        end else begin
          m_tick++;
        end
      end else if (m_mode == 2) begin
        if (m_wait == 0) begin
          exp_valid = 1'b1;
          exp_band  = 2'(ref_band(m_base, m_cnt));
          m_mode    = 0;
        end else begin
          m_wait--;
        end
      end
      exp_sample = (m_mode == 1) && (m_tick == m_gap);
    end
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_up();
    end
  end

  // compare every cycle, then drive the count for the current cycle
  always @(negedge clk) begin
    if (!done) begin
      chk("R3", sample, exp_sample, "sample_o");
      chk("R7", valid, exp_valid, "valid_o");
      chk(cur_req, band, exp_band, "band_o");
      if (exp_sample) count = 9'(pat_mode == 1 ? pat_val + m_n : pat_val);
      else count = 9'h1FF;
    end
  end

  task automatic launch(input logic [31:0] w, input int b, input int g,
                        input int pm, input int pv);
    word = w; base = 7'(b); gap = 8'(g); pat_mode = pm; pat_val = pv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic await_result(input string req, input int exp_b, input int exp_lat);
    int lat;
    lat = 0;
    while (!valid && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    chk(req, valid, 1, "result pulse seen");
    chk(req, band, exp_b, "band");
    chk(req, lat, exp_lat, "latency");
    @(negedge clk);
    chk("R7", valid, 0, "pulse width");
  endtask

  initial begin
    int cs[6];
    int bs[6];
    repeat (3) @(negedge clk);
    // R1: outputs in reset
    chk("R1", sample, 0, "sample_o in reset");
    chk("R1", valid, 0, "valid_o in reset");
    chk("R1", band, 0, "band_o in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", band, 0, "band_o after release");

    // R2: signed word skips sampling
    cur_req = "R2";
    launch(signed_word(150), 48, 0, 0, 0);
    await_result("R2", 0, 2);

    // R6: band edges with base 48
    cur_req = "R6";
    cs = '{159, 160, 179, 180, 219, 220};
    bs = '{0, 1, 1, 2, 2, 3};
    foreach (cs[i]) begin
      launch(signed_word(cs[i]), 48, 0, 0, 0);
      await_result("R6", bs[i], 2);
    end

    // R5: other base constants
    cur_req = "R5";
    launch(signed_word(300), 66, 0, 0, 0);
    await_result("R5", 3, 2);
    launch(signed_word(150), 55, 0, 0, 0);
    await_result("R5", 1, 2);
    launch(signed_word(100), 66, 0, 0, 0);
    await_result("R5", 0, 2);

    // R3: missing signature forces sampling
    cur_req = "R3";
    launch(32'hABCDF096, 48, 0, 0, 220);
    await_result("R3", 3, 130);
    launch(32'h0, 48, 1, 0, 160);
    await_result("R3", 1, 258);

    // R4: floor average (159.5 must grade as 159)
    cur_req = "R4";
    launch(32'h0, 48, 0, 1, 96);
    await_result("R4", 0, 130);
    launch(32'h0, 55, 2, 1, 120);
    await_result("R4", 2, 386);

    // R9: values outside strobe cycles are 511 and must be ignored
    cur_req = "R9";
    launch(32'h0, 48, 3, 0, 180);
    await_result("R9", 2, 514);
    repeat (20) @(negedge clk);
    chk("R9", band, 2, "band held between results");

    // R8: restarts
    cur_req = "R8";
    launch(32'h0, 48, 0, 0, 500);
    repeat (60) @(negedge clk);
    launch(32'h0, 48, 0, 0, 150);
    await_result("R8", 0, 130);
    launch(32'h0, 48, 0, 0, 180);
    repeat (100) @(negedge clk);
    launch(signed_word(220), 48, 0, 0, 0);
    await_result("R8", 3, 2);
    launch(signed_word(150), 48, 0, 0, 0);
    launch(signed_word(180), 48, 0, 0, 0);
    await_result("R8", 2, 2);

    // R10: inputs changed mid-pass are not used
    cur_req = "R10";
    launch(32'h0, 48, 1, 0, 180);
    repeat (5) @(negedge clk);
    base = 7'd127; gap = 8'd0; word = signed_word(0);
    await_result("R10", 2, 253);

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule